// File: doc/BRIEF.md
# Escaped Delimiter Frame Codec

This block carries a block of bytes across a plain byte channel that has no built-in notion of where a block begins or ends. The transmit half accepts payload bytes on a valid/ready stream, where a last flag marks the final byte of the block. It produces a frame on a second valid/ready stream. The frame opens with a start marker (0x01) and closes with a stop marker (0x04). Any payload byte that collides with one of the three reserved values (the two markers and the escape byte 0x1B) leaves the block as a pair: the escape byte followed by a substitute code.

The receive half watches a byte stream that has no back-pressure. It ignores anything outside a frame and locks onto start markers. It strips the markers, reverses the substitutions, and delivers the payload as beats. Each beat carries a byte, a keep bit, a last flag and an error flag. The block holds the most recent byte back by one beat so that it can mark that byte as the final one when the stop marker arrives. The two halves share only clock and reset, and a system can use them as a loopback pair or on their own.

Top module: `stuff_codec`

## Requirements
- R1: The transmit stream begins every frame with the byte 0x01 and ends it with the byte 0x04. Neither value appears anywhere between the two markers.
- R2: The encoder sends the payload byte 0x01 as 0x1B 0x78, the byte 0x04 as 0x1B 0x79 and the byte 0x1B as 0x1B 0x7A. It sends every other byte unchanged and in order.
- R3: The encoder holds `tx_in_ready` low while it offers the start marker, the substitute half of an escape pair or the stop marker. While `tx_out_ready` is low, `tx_out_data` and `tx_out_valid` stay steady, so the encoder loses no byte.
- R4: A frame for n payload bytes, k of them reserved, is exactly n + 2 + k bytes long.
- R5: The decoder delivers each payload byte of a good frame with keep=1 and err=0. Only the final byte of the frame carries last=1.
- R6: The decoder discards bytes that arrive before the first start marker or after a stop marker, and they cause no output beat.
- R7: When a start marker arrives inside a frame, the decoder closes the current frame with one beat that has last=1 and err=1. That beat carries the byte still held back, if there is one (keep=1), and otherwise has keep=0. The decoder then receives a new frame.
- R8: An escape byte followed by anything other than 0x78, 0x79 or 0x7A closes the frame with a beat that has last=1 and err=1. This includes the case where the escape byte is followed by the stop marker. The keep bit of that beat follows the same rule as in R7, and the decoder ignores the bytes up to the next start marker.
- R9: A start marker followed at once by a stop marker gives exactly one beat, with keep=0, last=1 and err=0.
- R10: Every output beat of the decoder appears in the cycle after the input byte that caused it, and each input byte causes at most one beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_in_data | input | 8 | Payload byte to encode |
| tx_in_valid | input | 1 | Payload byte offered |
| tx_in_last | input | 1 | Offered byte ends the block |
| tx_in_ready | output | 1 | Encoder takes the payload byte this cycle |
| tx_out_data | output | 8 | Encoded frame byte |
| tx_out_valid | output | 1 | Frame byte offered |
| tx_out_ready | input | 1 | Channel takes the frame byte |
| rx_in_data | input | 8 | Received channel byte |
| rx_in_valid | input | 1 | Received byte present this cycle |
| rx_out_data | output | 8 | Decoded payload byte |
| rx_out_valid | output | 1 | Beat present |
| rx_out_keep | output | 1 | Beat carries a payload byte |
| rx_out_last | output | 1 | Beat closes the frame |
| rx_out_err | output | 1 | Frame closed by an error |

## Verification
The encoder is tested with payloads of four kinds: ordinary bytes only, one reserved value of each kind mixed with ordinary bytes, reserved values only, and a long counting sequence. These cases separate three faults: wrong substitutions, lost bytes around an escape pair, and wrong frame lengths. Each is tried with the channel always ready, ready two cycles in three, and ready one cycle in four, which shows whether the input handshake stays frozen while a marker or a substitute is pending. The encoder output loops into the decoder so that every byte is checked end to end. The decoder is also driven directly with the following: leading garbage, an empty frame, a frame cut by a second start marker, escapes followed by a wrong code or by the stop marker, and escaped reserved bytes. These cases show whether the held-back byte reaches the closing beat and whether the error beat is kept apart from a normal end of frame.

// File: rtl/stuff_pkg.sv
package stuff_pkg;

   localparam int NUM_RSV = 3;

   typedef enum logic [1:0] {
      TX_IDLE = 2'd0,
      TX_BODY = 2'd1,
      TX_SUB  = 2'd2,
      TX_END  = 2'd3
   } tx_st_e;

   typedef enum logic [1:0] {
      RX_HUNT = 2'd0,
      RX_BODY = 2'd1,
      RX_ESC  = 2'd2
   } rx_st_e;

endpackage

// File: rtl/stuff_map.sv
module stuff_map #(
   parameter int DATA_W = 8,
   parameter int LANES  = 3,
   parameter logic [LANES-1:0][DATA_W-1:0] RSV = '0,
   parameter logic [LANES-1:0][DATA_W-1:0] SUB = '0
) (
   input  logic [DATA_W-1:0] fwd_in,
   output logic              fwd_hit,
   output logic [DATA_W-1:0] fwd_sub,
   input  logic [DATA_W-1:0] rev_in,
   output logic              rev_hit,
   output logic [DATA_W-1:0] rev_raw
);

   logic [LANES-1:0] f_m;
   logic [LANES-1:0] r_m;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign f_m[i] = (fwd_in == RSV[i]);
      assign r_m[i] = (rev_in == SUB[i]);
   end

   assign fwd_hit = |f_m;
   assign rev_hit = |r_m;

   always_comb begin
      fwd_sub = '0;
      rev_raw = '0;
      for (int j = 0; j < LANES; j++) begin
         if (f_m[j]) fwd_sub = fwd_sub | SUB[j];
         if (r_m[j]) rev_raw = rev_raw | RSV[j];
      end
   end

endmodule

// File: rtl/stuff_enc.sv
module stuff_enc
   import stuff_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [NUM_RSV-1:0][DATA_W-1:0] RSV = '0,
   parameter logic [NUM_RSV-1:0][DATA_W-1:0] SUB = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   input  logic              out_ready
);

   localparam logic [DATA_W-1:0] SOF = RSV[0];
   localparam logic [DATA_W-1:0] EOF = RSV[1];
   localparam logic [DATA_W-1:0] ESC = RSV[2];

   tx_st_e            st, st_n;
   logic [DATA_W-1:0] sub_r, sub_n;
   logic              last_r, last_n;
   logic              hit;
   logic [DATA_W-1:0] hit_sub;
   logic              rev_unused_hit;
   logic [DATA_W-1:0] rev_unused_raw;

   stuff_map #(
      .DATA_W(DATA_W), .LANES(NUM_RSV), .RSV(RSV), .SUB(SUB)
   ) u_map (
      .fwd_in (in_data),
      .fwd_hit(hit),
      .fwd_sub(hit_sub),
      .rev_in ('0),
      .rev_hit(rev_unused_hit),
      .rev_raw(rev_unused_raw)
   );

   always_comb begin
      st_n      = st;
      sub_n     = sub_r;
      last_n    = last_r;
      out_valid = 1'b0;
      out_data  = in_data;
      in_ready  = 1'b0;
      unique case (st)
         TX_IDLE: begin
            out_data  = SOF;
            out_valid = in_valid;
            if (in_valid && out_ready) st_n = TX_BODY;
         end
         TX_BODY: begin
            out_valid = in_valid;
            in_ready  = out_ready;
            out_data  = hit ? ESC : in_data;
            if (in_valid && out_ready) begin
               if (hit) begin
                  st_n   = TX_SUB;
                  sub_n  = hit_sub;
                  last_n = in_last;
               end else if (in_last) begin
                  st_n = TX_END;
               end
            end
         end
         TX_SUB: begin
            out_data  = sub_r;
            out_valid = 1'b1;
            if (out_ready) st_n = last_r ? TX_END : TX_BODY;
         end
         TX_END: begin
            out_data  = EOF;
            out_valid = 1'b1;
            if (out_ready) st_n = TX_IDLE;
         end
         default: st_n = TX_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         sub_r  <= '0;
         last_r <= 1'b0;
      end else begin
         st     <= st_n;
         sub_r  <= sub_n;
         last_r <= last_n;
      end
   end

endmodule

// File: rtl/stuff_dec.sv
module stuff_dec
   import stuff_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [NUM_RSV-1:0][DATA_W-1:0] RSV = '0,
   parameter logic [NUM_RSV-1:0][DATA_W-1:0] SUB = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_keep,
   output logic              out_last,
   output logic              out_err
);

   localparam logic [DATA_W-1:0] SOF = RSV[0];
   localparam logic [DATA_W-1:0] EOF = RSV[1];
   localparam logic [DATA_W-1:0] ESC = RSV[2];

   rx_st_e            st, st_n;
   logic              pend_v, pend_v_n;
   logic [DATA_W-1:0] pend_d, pend_d_n;
   logic              emit, emit_keep, emit_last, emit_err;
   logic              fwd_unused_hit;
   logic [DATA_W-1:0] fwd_unused_sub;
   logic              sub_ok;
   logic [DATA_W-1:0] sub_raw;

   stuff_map #(
      .DATA_W(DATA_W), .LANES(NUM_RSV), .RSV(RSV), .SUB(SUB)
   ) u_map (
      .fwd_in ('0),
      .fwd_hit(fwd_unused_hit),
      .fwd_sub(fwd_unused_sub),
      .rev_in (in_data),
      .rev_hit(sub_ok),
      .rev_raw(sub_raw)
   );

   always_comb begin
      st_n      = st;
      pend_v_n  = pend_v;
      pend_d_n  = pend_d;
      emit      = 1'b0;
      emit_keep = pend_v;
      emit_last = 1'b0;
      emit_err  = 1'b0;
      if (in_valid) begin
         if (in_data == SOF) begin
            if (st != RX_HUNT) begin
               emit      = 1'b1;
               emit_last = 1'b1;
               emit_err  = 1'b1;
            end
            pend_v_n = 1'b0;
            st_n     = RX_BODY;
         end else begin
            unique case (st)
               RX_HUNT: st_n = RX_HUNT;
               RX_BODY: begin
                  if (in_data == EOF) begin
                     emit      = 1'b1;
                     emit_last = 1'b1;
                     pend_v_n  = 1'b0;
                     st_n      = RX_HUNT;
                  end else if (in_data == ESC) begin
                     st_n = RX_ESC;
                  end else begin
                     emit     = pend_v;
                     pend_d_n = in_data;
                     pend_v_n = 1'b1;
                  end
               end
               RX_ESC: begin
                  if (sub_ok) begin
                     emit     = pend_v;
                     pend_d_n = sub_raw;
                     pend_v_n = 1'b1;
                     st_n     = RX_BODY;
                  end else begin
                     emit      = 1'b1;
                     emit_last = 1'b1;
                     emit_err  = 1'b1;
                     pend_v_n  = 1'b0;
                     st_n      = RX_HUNT;
                  end
               end
               default: st_n = RX_HUNT;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= RX_HUNT;
         pend_v    <= 1'b0;
         pend_d    <= '0;
         out_valid <= 1'b0;
         out_data  <= '0;
         out_keep  <= 1'b0;
         out_last  <= 1'b0;
         out_err   <= 1'b0;
      end else begin
         st        <= st_n;
         pend_v    <= pend_v_n;
         pend_d    <= pend_d_n;
         out_valid <= emit;
         if (emit) begin
            out_data <= emit_keep ? pend_d : '0;
            out_keep <= emit_keep;
            out_last <= emit_last;
            out_err  <= emit_err;
         end
      end
   end

endmodule

// File: rtl/stuff_codec.sv
module stuff_codec
   import stuff_pkg::*;
#(
   parameter int               DATA_W   = 8,
   parameter logic [DATA_W-1:0] SOF_BYTE = 8'h01,
   parameter logic [DATA_W-1:0] EOF_BYTE = 8'h04,
   parameter logic [DATA_W-1:0] ESC_BYTE = 8'h1B,
   parameter logic [DATA_W-1:0] SUB_SOF  = 8'h78,
   parameter logic [DATA_W-1:0] SUB_EOF  = 8'h79,
   parameter logic [DATA_W-1:0] SUB_ESC  = 8'h7A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_in_data,
   input  logic              tx_in_valid,
   input  logic              tx_in_last,
   output logic              tx_in_ready,
   output logic [DATA_W-1:0] tx_out_data,
   output logic              tx_out_valid,
   input  logic              tx_out_ready,
   input  logic [DATA_W-1:0] rx_in_data,
   input  logic              rx_in_valid,
   output logic [DATA_W-1:0] rx_out_data,
   output logic              rx_out_valid,
   output logic              rx_out_keep,
   output logic              rx_out_last,
   output logic              rx_out_err
);

   localparam logic [NUM_RSV-1:0][DATA_W-1:0] RSV_SET = {ESC_BYTE, EOF_BYTE, SOF_BYTE};
   localparam logic [NUM_RSV-1:0][DATA_W-1:0] SUB_SET = {SUB_ESC, SUB_EOF, SUB_SOF};

   if (DATA_W < 2) begin : g_bad_width
      $error("stuff_codec: DATA_W must be at least 2");
   end
   if (SOF_BYTE == EOF_BYTE || SOF_BYTE == ESC_BYTE || EOF_BYTE == ESC_BYTE) begin : g_bad_rsv
      $error("stuff_codec: reserved codes must differ");
   end
   if (SUB_SOF == SUB_EOF || SUB_SOF == SUB_ESC || SUB_EOF == SUB_ESC) begin : g_bad_sub
      $error("stuff_codec: substitute codes must differ");
   end
   for (genvar i = 0; i < NUM_RSV; i++) begin : g_chk_sub
      for (genvar j = 0; j < NUM_RSV; j++) begin : g_pair
         if (SUB_SET[i] == RSV_SET[j]) begin : g_clash
            $error("stuff_codec: a substitute code equals a reserved code");
         end
      end
   end

   stuff_enc #(
      .DATA_W(DATA_W), .RSV(RSV_SET), .SUB(SUB_SET)
   ) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (tx_in_data),
      .in_valid (tx_in_valid),
      .in_last  (tx_in_last),
      .in_ready (tx_in_ready),
      .out_data (tx_out_data),
      .out_valid(tx_out_valid),
      .out_ready(tx_out_ready)
   );

   stuff_dec #(
      .DATA_W(DATA_W), .RSV(RSV_SET), .SUB(SUB_SET)
   ) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_data  (rx_in_data),
      .in_valid (rx_in_valid),
      .out_data (rx_out_data),
      .out_valid(rx_out_valid),
      .out_keep (rx_out_keep),
      .out_last (rx_out_last),
      .out_err  (rx_out_err)
   );

endmodule

// File: rtl/stuff_codec_chk.sv
module stuff_codec_chk #(
   parameter int               DATA_W   = 8,
   parameter logic [DATA_W-1:0] SOF_BYTE = 8'h01,
   parameter logic [DATA_W-1:0] ESC_BYTE = 8'h1B,
   parameter logic [DATA_W-1:0] SUB_SOF  = 8'h78,
   parameter logic [DATA_W-1:0] SUB_EOF  = 8'h79,
   parameter logic [DATA_W-1:0] SUB_ESC  = 8'h7A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_in_ready,
   input logic [DATA_W-1:0] tx_out_data,
   input logic              tx_out_valid,
   input logic              tx_out_ready,
   input logic              rx_in_valid,
   input logic              rx_out_valid,
   input logic              rx_out_keep,
   input logic              rx_out_last,
   input logic              rx_out_err
);

   AST_TX_SOF_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_out_valid && tx_out_data == SOF_BYTE) |-> !tx_in_ready);  // R3
   AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_out_valid && !tx_out_ready) |=> (tx_out_valid && $stable(tx_out_data)));  // R3
   AST_TX_ESC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_out_valid && tx_out_ready && tx_out_data == ESC_BYTE) |=>
      (tx_out_valid && (tx_out_data == SUB_SOF || tx_out_data == SUB_EOF || tx_out_data == SUB_ESC)));  // R2
   AST_TX_SUB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_out_valid && tx_out_ready && tx_out_data == ESC_BYTE) |=> !tx_in_ready);  // R3
   AST_RX_ERR_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_valid && rx_out_err) |-> rx_out_last);  // R7
   AST_RX_EMPTY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_out_valid && !rx_out_keep) |-> rx_out_last);  // R9
   AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rx_out_valid |-> $past(rx_in_valid));  // R10

endmodule

bind stuff_codec stuff_codec_chk #(
   .DATA_W(DATA_W), .SOF_BYTE(SOF_BYTE), .ESC_BYTE(ESC_BYTE),
   .SUB_SOF(SUB_SOF), .SUB_EOF(SUB_EOF), .SUB_ESC(SUB_ESC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tx_in_ready (tx_in_ready),
   .tx_out_data (tx_out_data),
   .tx_out_valid(tx_out_valid),
   .tx_out_ready(tx_out_ready),
   .rx_in_valid (rx_in_valid),
   .rx_out_valid(rx_out_valid),
   .rx_out_keep (rx_out_keep),
   .rx_out_last (rx_out_last),
   .rx_out_err  (rx_out_err)
);

// File: tb/sim_stuff_codec.sv
module sim_stuff_codec;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] tx_in_data = '0;
   logic       tx_in_valid = 1'b0;
   logic       tx_in_last = 1'b0;
   logic       tx_in_ready;
   logic [7:0] tx_out_data;
   logic       tx_out_valid;
   logic       tx_out_ready = 1'b0;
   logic [7:0] rx_in_data;
   logic       rx_in_valid;
   logic [7:0] rx_out_data;
   logic       rx_out_valid, rx_out_keep, rx_out_last, rx_out_err;

   logic       loop_en = 1'b1;
   logic [7:0] drv_data = '0;
   logic       drv_valid = 1'b0;
   int         bp_mode = 0;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   logic [7:0] tx_exp[$];
   int         len_exp[$];
   logic [7:0] rx_exp_d[$];
   logic [2:0] rx_exp_f[$];   // {keep, last, err}
   int         tx_cnt = 0;

   assign rx_in_data  = loop_en ? tx_out_data : drv_data;
   assign rx_in_valid = loop_en ? (tx_out_valid && tx_out_ready) : drv_valid;

   always #(CLK_PERIOD/2) clk = ~clk;

   stuff_codec u0 (
      .clk(clk), .rst_n(rst_n),
      .tx_in_data(tx_in_data), .tx_in_valid(tx_in_valid), .tx_in_last(tx_in_last),
      .tx_in_ready(tx_in_ready),
      .tx_out_data(tx_out_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
      .rx_in_data(rx_in_data), .rx_in_valid(rx_in_valid),
      .rx_out_data(rx_out_data), .rx_out_valid(rx_out_valid), .rx_out_keep(rx_out_keep),
      .rx_out_last(rx_out_last), .rx_out_err(rx_out_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // channel back-pressure pattern
   initial begin
      int c = 0;
      forever begin
         @(posedge clk); #1;
         c++;
         case (bp_mode)
            0: tx_out_ready = 1'b1;
            1: tx_out_ready = (c % 3) != 0;
            default: tx_out_ready = (c % 4) == 0;
         endcase
      end
   end

   // transmit monitor: frame bytes and frame length (R1 R2 R4)
   always @(negedge clk) begin
      if (rst_n && tx_out_valid && tx_out_ready) begin
         tx_cnt++;
         if (tx_exp.size() == 0) begin
            check(1'b0, cur_req, "unexpected tx byte", tx_out_data, 0);
         end else begin
            logic [7:0] e;
            e = tx_exp.pop_front();
            check(tx_out_data == e, cur_req, "tx byte", tx_out_data, e);
         end
         if (tx_out_data == 8'h04) begin
            int l;
            l = (len_exp.size() != 0) ? len_exp.pop_front() : -1;
            check(tx_cnt == l, "R4", "frame length", tx_cnt, l);
            tx_cnt = 0;
         end
      end
   end

   // receive monitor (R5 R7 R8 R9)
   always @(negedge clk) begin
      if (rst_n && rx_out_valid) begin
         if (rx_exp_f.size() == 0) begin
            check(1'b0, cur_req, "unexpected rx beat", rx_out_data, 0);
         end else begin
            logic [7:0] ed;
            logic [2:0] ef;
            ed = rx_exp_d.pop_front();
            ef = rx_exp_f.pop_front();
            check({rx_out_keep, rx_out_last, rx_out_err} == ef, cur_req, "rx flags",
                  {rx_out_keep, rx_out_last, rx_out_err}, ef);
            if (ef[2]) check(rx_out_data == ed, cur_req, "rx data", rx_out_data, ed);
         end
      end
   end

   task automatic exp_rx(input logic [7:0] d, input logic keep, input logic last,
                         input logic err);
      rx_exp_d.push_back(d);
      rx_exp_f.push_back({keep, last, err});
   endtask

   task automatic send_frame(input logic [7:0] p[$]);
      int n_esc = 0;
      tx_exp.push_back(8'h01);
      foreach (p[i]) begin
         case (p[i])
            8'h01: begin tx_exp.push_back(8'h1B); tx_exp.push_back(8'h78); n_esc++; end
            8'h04: begin tx_exp.push_back(8'h1B); tx_exp.push_back(8'h79); n_esc++; end
            8'h1B: begin tx_exp.push_back(8'h1B); tx_exp.push_back(8'h7A); n_esc++; end
            default: tx_exp.push_back(p[i]);
         endcase
         exp_rx(p[i], 1'b1, i == p.size() - 1, 1'b0);
      end
      tx_exp.push_back(8'h04);
      len_exp.push_back(p.size() + 2 + n_esc);
      foreach (p[i]) begin
         tx_in_data  = p[i];
         tx_in_last  = (i == p.size() - 1);
         tx_in_valid = 1'b1;
         while (1) begin
            @(negedge clk);
            if (tx_in_ready) break;
         end
         @(posedge clk); #1;
      end
      tx_in_valid = 1'b0;
      tx_in_last  = 1'b0;
   endtask

   task automatic rx_byte(input logic [7:0] b, output logic seen);
      drv_data  = b;
      drv_valid = 1'b1;
      @(posedge clk); #1;
      drv_valid = 1'b0;
      @(negedge clk);
      seen = rx_out_valid;
   endtask

   task automatic drain();
      int w = 0;
      while ((tx_exp.size() != 0 || rx_exp_f.size() != 0) && w < 2000) begin
         @(posedge clk);
         w++;
      end
      repeat (3) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      check(1'b0, "R0", "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      logic s;
      logic [7:0] q[$];
      repeat (3) @(posedge clk);
      #1;
      // reset state: nothing offered, input not taken (R3, R10)
      check(tx_out_valid == 1'b0, "R3", "reset tx_out_valid", tx_out_valid, 0);
      check(tx_in_ready == 1'b0, "R3", "reset tx_in_ready", tx_in_ready, 0);
      check(rx_out_valid == 1'b0, "R10", "reset rx_out_valid", rx_out_valid, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // loopback: encoder checked at its output, decoder at its beats
      cur_req = "R2"; bp_mode = 0;
      q = '{8'h41, 8'h01, 8'h42, 8'h04, 8'h1B, 8'h43};
      send_frame(q);
      cur_req = "R1"; bp_mode = 0;
      q = '{8'h55};
      send_frame(q);
      cur_req = "R3"; bp_mode = 2;
      q = '{8'h1B, 8'h1B, 8'h01, 8'h04};
      send_frame(q);
      cur_req = "R5"; bp_mode = 1;
      q = {};
      for (int i = 0; i < 20; i++) q.push_back(8'(i * 13));
      send_frame(q);
      drain();
      check(tx_exp.size() == 0, "R3", "tx bytes outstanding", tx_exp.size(), 0);
      check(rx_exp_f.size() == 0, "R5", "rx beats outstanding", rx_exp_f.size(), 0);

      // direct receive stimulus
      loop_en = 1'b1; bp_mode = 0;
      @(posedge clk); #1;
      loop_en = 1'b0;
      cur_req = "R6";
      rx_byte(8'h33, s); rx_byte(8'h04, s); rx_byte(8'h1B, s); rx_byte(8'h7A, s);
      check(s == 1'b0, "R6", "beat outside frame", s, 0);
      exp_rx(8'h41, 1, 0, 0); exp_rx(8'h42, 1, 1, 0);
      rx_byte(8'h01, s);
      rx_byte(8'h41, s);
      check(s == 1'b0, "R10", "held-back first byte", s, 0);
      rx_byte(8'h42, s);
      check(s == 1'b1, "R10", "beat one cycle after byte", s, 1);
      rx_byte(8'h04, s);
      check(s == 1'b1, "R10", "closing beat one cycle after stop", s, 1);
      rx_byte(8'h99, s);
      check(s == 1'b0, "R6", "beat after stop marker", s, 0);

      cur_req = "R9";
      exp_rx(8'h00, 0, 1, 0);
      rx_byte(8'h01, s); rx_byte(8'h04, s);

      cur_req = "R7";
      exp_rx(8'h43, 1, 0, 0); exp_rx(8'h44, 1, 1, 1); exp_rx(8'h45, 1, 1, 0);
      rx_byte(8'h01, s); rx_byte(8'h43, s); rx_byte(8'h44, s);
      rx_byte(8'h01, s); rx_byte(8'h45, s); rx_byte(8'h04, s);
      exp_rx(8'h00, 0, 1, 1); exp_rx(8'h00, 0, 1, 0);
      rx_byte(8'h01, s); rx_byte(8'h01, s); rx_byte(8'h04, s);

      cur_req = "R8";
      exp_rx(8'h46, 1, 1, 1);
      rx_byte(8'h01, s); rx_byte(8'h46, s); rx_byte(8'h1B, s); rx_byte(8'h41, s);
      rx_byte(8'h47, s); rx_byte(8'h04, s);
      check(s == 1'b0, "R8", "bytes after bad escape ignored", s, 0);
      exp_rx(8'h00, 0, 1, 1);
      rx_byte(8'h01, s); rx_byte(8'h1B, s); rx_byte(8'h04, s);
      exp_rx(8'h00, 0, 1, 1);
      rx_byte(8'h01, s); rx_byte(8'h1B, s); rx_byte(8'h1B, s);

      cur_req = "R5";
      exp_rx(8'h01, 1, 0, 0); exp_rx(8'h04, 1, 0, 0); exp_rx(8'h1B, 1, 1, 0);
      rx_byte(8'h01, s); rx_byte(8'h1B, s); rx_byte(8'h78, s); rx_byte(8'h1B, s);
      rx_byte(8'h79, s); rx_byte(8'h1B, s); rx_byte(8'h7A, s); rx_byte(8'h04, s);

      drain();
      check(rx_exp_f.size() == 0, "R7", "direct beats outstanding", rx_exp_f.size(), 0);
      finish_run();
   end

endmodule